// File: doc/BRIEF.md
# JTAG to Debug-Module Bridge

This block is a JTAG test access port whose data registers reach an on-chip debug module over a simple synchronous request/acknowledge port. The TAP has a 4-bit instruction register. Besides an identification register, a 1-bit bypass register and a 3-bit loop-test register, three instructions give access to the debug module. One holds the 8-bit debug-module address. One reads 64 bits from that address. One writes 64 bits there and, in the same scan, shifts out what the register held before the write.

TCK, TMS and TDI are sampled in the system clock. A rising TCK edge is detected one clock after it is registered, and every TAP action happens on that detected edge. Selecting the read or write-and-read instruction starts a read of the held address, so that the first data scan already has data to capture. The Update-DR of a read scan starts another read, and the result is loaded in Capture-DR of the next scan. The Update-DR of a write-and-read scan issues the write and then a read-back, so the next scan returns the value now in the register.

Top module: `jtag_dmi_bridge`

## Requirements
- R1: Synchronous reset, or five consecutive detected TCK rises with TMS high from any state, puts the TAP in Test-Logic-Reset. While in that state the instruction register holds the identification code (1).
- R2: The instruction register is 4 bits and is shifted LSB first. Capture-IR loads 4'b0001, so every instruction scan shifts out the value 1. The new code takes effect when the TAP leaves Update-IR.
- R3: Code 1 selects a 32-bit register that captures 0x000018FF.
- R4: Code 4 selects a 3-bit loop register. Capture-DR loads `lb_in`, and leaving Update-DR drives the shifted value onto `lb_out` (reset value 0).
- R5: Codes 0, 2, 3 and 8 to 15 select a 1-bit bypass register that captures 0. An n-bit scan therefore returns its input delayed by one bit, with 0 in bit 0.
- R6: Code 5 selects an 8-bit address register. Capture-DR loads the current address (0 after reset), leaving Update-DR stores the shifted value, and later debug-module accesses use it on `dm_addr`.
- R7: Leaving Update-IR with code 6 or 7 starts a debug-module read of the held address. Leaving Update-DR with code 6 starts another read. Capture-DR with code 6 or 7 loads the data of the most recently completed read, so data that changes after a read first appears two scans later.
- R8: Leaving Update-DR with code 7 issues a write (`dm_we`=1) of the 64 shifted bits to the held address, followed by a read (`dm_we`=0) of the same address. The 64 bits shifted out in that scan are the register's contents from before the write.
- R9: `dm_req` stays high, with `dm_addr`, `dm_wdata` and `dm_we` stable, until `dm_ack` is seen. The request completes in the cycle `dm_ack` is high, and `dm_we` is never high without `dm_req`.
- R10: In Shift-IR and Shift-DR, `tdo` shows bit 0 of the selected register, and the register shifts toward bit 0 on each detected TCK rise. In all other states `tdo` is 0.
- R11: After reset, `tdo` is 0, `dm_req` is low and the address register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the JTAG pins |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | Test clock, sampled in `clk` |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| lb_in | input | 3 | Parallel input to the loop register |
| lb_out | output | 3 | Parallel output of the loop register |
| dm_req | output | 1 | Debug-module request |
| dm_we | output | 1 | Request is a write |
| dm_addr | output | 8 | Debug-module register address |
| dm_wdata | output | 64 | Write data |
| dm_ack | input | 1 | One-cycle completion from the debug module |
| dm_rdata | input | 64 | Read data, valid with `dm_ack` |

## Verification
The bench builds the block with its default parameters: a 4-bit instruction register, 64-bit debug data, an 8-bit address and a 3-bit loop register with `lb_out` wired back to `lb_in`. These defaults allow full 64-bit scans, bypass checks at both ends of the unused code range (0 and 15), and a bench-side change to debug-module contents that separates stale capture from fresh capture. The debug-module model answers after three clocks. TCK runs at seven clocks per period, so every read finishes before the next Capture-DR.

// File: rtl/jdb_pkg.sv
package jdb_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    typedef enum logic [2:0] {
        DS_BYPASS, DS_IDCODE, DS_LOOP, DS_ADDR, DS_READ, DS_WRITE
    } dr_sel_t;

    typedef enum logic [1:0] {
        DQ_IDLE, DQ_WRITE, DQ_READ
    } dmi_phase_t;

    localparam int unsigned CODE_IDCODE = 1;
    localparam int unsigned CODE_LOOP   = 4;
    localparam int unsigned CODE_ADDR   = 5;
    localparam int unsigned CODE_READ   = 6;
    localparam int unsigned CODE_WRITE  = 7;
    localparam logic [31:0] IDCODE_DEFAULT = 32'h0000_18FF;

    // TAP controller successor state for one TCK rise
    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        case (s)
            TS_RESET:  return m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: return m ? TS_SEL_DR : TS_IDLE;
            default:   return TS_RESET;
        endcase
    endfunction

endpackage

// File: rtl/jdb_tap_fsm.sv
module jdb_tap_fsm
    import jdb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tck_rise,
    input  logic       tms,
    output tap_state_t state
);

    always_ff @(posedge clk) begin
        if (rst)
            state <= TS_RESET;
        else if (tck_rise)
            state <= tap_next(state, tms);
    end

    // Checker: count consecutive TCK rises with TMS high (saturates at 5)
    logic [2:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= 3'd0;
        else if (tck_rise)
            hi_run <= !tms ? 3'd0 : (hi_run == 3'd5 ? 3'd5 : hi_run + 3'd1);
    end

    assert_five_tms_reset_R1: assert property (@(posedge clk) disable iff (rst)
        (hi_run == 3'd5) |-> (state == TS_RESET));

endmodule

// File: rtl/jdb_dr_chain.sv
module jdb_dr_chain
    import jdb_pkg::*;
#(
    parameter int unsigned IR_W      = 4,
    parameter int unsigned DW        = 64,
    parameter int unsigned AW        = 8,
    parameter int unsigned LB_W      = 3,
    parameter logic [31:0] ID_VAL    = IDCODE_DEFAULT,
    parameter int unsigned INS_ID    = CODE_IDCODE,
    parameter int unsigned INS_LOOP  = CODE_LOOP,
    parameter int unsigned INS_ADDR  = CODE_ADDR,
    parameter int unsigned INS_READ  = CODE_READ,
    parameter int unsigned INS_WRITE = CODE_WRITE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tck_rise,
    input  logic            tdi,
    input  tap_state_t      state,
    input  logic [LB_W-1:0] lb_in,
    output logic [LB_W-1:0] lb_out,
    input  logic [DW-1:0]   rd_data,
    output logic            rd_go,
    output logic            wr_go,
    output logic [DW-1:0]   shift_q,
    output logic [AW-1:0]   addr_q,
    output logic            tdo
);

    localparam logic [IR_W-1:0] IR_ID    = IR_W'(INS_ID);
    localparam logic [IR_W-1:0] IR_LOOP  = IR_W'(INS_LOOP);
    localparam logic [IR_W-1:0] IR_ADDR  = IR_W'(INS_ADDR);
    localparam logic [IR_W-1:0] IR_READ  = IR_W'(INS_READ);
    localparam logic [IR_W-1:0] IR_WRITE = IR_W'(INS_WRITE);
    localparam logic [IR_W-1:0] IR_CAPT  = IR_W'(1);

    logic [IR_W-1:0] ir_sr, ir_q;
    logic [DW-1:0]   dr_sr, dr_nxt, dr_cap, dr_half;
    dr_sel_t         sel;
    int              len;

    logic do_cap_ir, do_sh_ir, do_upd_ir, do_cap_dr, do_sh_dr, do_upd_dr;
    assign do_cap_ir = tck_rise && (state == TS_CAP_IR);
    assign do_sh_ir  = tck_rise && (state == TS_SH_IR);
    assign do_upd_ir = tck_rise && (state == TS_UPD_IR);
    assign do_cap_dr = tck_rise && (state == TS_CAP_DR);
    assign do_sh_dr  = tck_rise && (state == TS_SH_DR);
    assign do_upd_dr = tck_rise && (state == TS_UPD_DR);

    // instruction decode, length and capture source
    always_comb begin
        if      (ir_q == IR_ID)    sel = DS_IDCODE;
        else if (ir_q == IR_LOOP)  sel = DS_LOOP;
        else if (ir_q == IR_ADDR)  sel = DS_ADDR;
        else if (ir_q == IR_READ)  sel = DS_READ;
        else if (ir_q == IR_WRITE) sel = DS_WRITE;
        else                       sel = DS_BYPASS;
    end

    always_comb begin
        case (sel)
            DS_IDCODE: begin len = 32;        dr_cap = DW'(ID_VAL); end
            DS_LOOP:   begin len = int'(LB_W); dr_cap = DW'(lb_in);  end
            DS_ADDR:   begin len = int'(AW);   dr_cap = DW'(addr_q); end
            DS_READ,
            DS_WRITE:  begin len = int'(DW);   dr_cap = rd_data;     end
            default:   begin len = 1;         dr_cap = '0;          end
        endcase
    end

    // variable-length shift: new bit enters at position len-1
    assign dr_half = dr_sr >> 1;
    always_comb begin
        for (int i = 0; i < int'(DW); i++) begin
            if (i == len - 1)     dr_nxt[i] = tdi;
            else if (i < len - 1) dr_nxt[i] = dr_half[i];
            else                  dr_nxt[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_sr <= '0;
            ir_q  <= IR_ID;
        end else begin
            if (state == TS_RESET) ir_q <= IR_ID;
            if (do_cap_ir)      ir_sr <= IR_CAPT;
            else if (do_sh_ir)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            if (do_upd_ir)      ir_q  <= ir_sr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dr_sr  <= '0;
            addr_q <= '0;
            lb_out <= '0;
        end else begin
            if (do_cap_dr)     dr_sr <= dr_cap;
            else if (do_sh_dr) dr_sr <= dr_nxt;
            if (do_upd_dr && sel == DS_ADDR) addr_q <= dr_sr[AW-1:0];
            if (do_upd_dr && sel == DS_LOOP) lb_out <= dr_sr[LB_W-1:0];
        end
    end

    assign rd_go = (do_upd_ir && (ir_sr == IR_READ || ir_sr == IR_WRITE))
                || (do_upd_dr && sel == DS_READ);
    assign wr_go = do_upd_dr && sel == DS_WRITE;
    assign shift_q = dr_sr;

    always_comb begin
        case (state)
            TS_SH_IR: tdo = ir_sr[0];
            TS_SH_DR: tdo = dr_sr[0];
            default:  tdo = 1'b0;
        endcase
    end

    assert_ir_default_R1: assert property (@(posedge clk) disable iff (rst)
        (state == TS_RESET) |=> (ir_q == IR_ID));

endmodule

// File: rtl/jdb_dmi_seq.sv
module jdb_dmi_seq
    import jdb_pkg::*;
#(
    parameter int unsigned DW = 64,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    output logic          dm_req,
    output logic          dm_we,
    output logic [AW-1:0] dm_addr,
    output logic [DW-1:0] dm_wdata,
    input  logic          dm_ack,
    input  logic [DW-1:0] dm_rdata,
    output logic [DW-1:0] rd_hold
);

    dmi_phase_t phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= DQ_IDLE;
            dm_req   <= 1'b0;
            dm_we    <= 1'b0;
            dm_addr  <= '0;
            dm_wdata <= '0;
            rd_hold  <= '0;
        end else begin
            case (phase)
                DQ_IDLE: begin
                    if (wr_go) begin
                        phase    <= DQ_WRITE;
                        dm_req   <= 1'b1;
                        dm_we    <= 1'b1;
                        dm_addr  <= addr_in;
                        dm_wdata <= wdata_in;
                    end else if (rd_go) begin
                        phase   <= DQ_READ;
                        dm_req  <= 1'b1;
                        dm_we   <= 1'b0;
                        dm_addr <= addr_in;
                    end
                end
                DQ_WRITE: begin
                    if (dm_ack) begin
                        phase <= DQ_READ;
                        dm_we <= 1'b0;
                    end
                end
                DQ_READ: begin
                    if (dm_ack) begin
                        phase   <= DQ_IDLE;
                        dm_req  <= 1'b0;
                        rd_hold <= dm_rdata;
                    end
                end
                default: phase <= DQ_IDLE;
            endcase
        end
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (dm_req && !dm_ack) |=> dm_req);

    assert_req_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (dm_req && !dm_ack) |=> ($stable(dm_addr) && $stable(dm_wdata) && $stable(dm_we)));

    assert_we_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> dm_req);

    assert_write_then_read_R8: assert property (@(posedge clk) disable iff (rst)
        (dm_req && dm_we && dm_ack) |=> (dm_req && !dm_we && $stable(dm_addr)));

endmodule

// File: rtl/jtag_dmi_bridge.sv
module jtag_dmi_bridge
    import jdb_pkg::*;
#(
    parameter int unsigned IR_W   = 4,
    parameter int unsigned DW     = 64,
    parameter int unsigned AW     = 8,
    parameter int unsigned LB_W   = 3,
    parameter logic [31:0] ID_VAL = IDCODE_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tck,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    input  logic [LB_W-1:0] lb_in,
    output logic [LB_W-1:0] lb_out,
    output logic            dm_req,
    output logic            dm_we,
    output logic [AW-1:0]   dm_addr,
    output logic [DW-1:0]   dm_wdata,
    input  logic            dm_ack,
    input  logic [DW-1:0]   dm_rdata
);

    // pin sampling in the system clock
    logic tck_q, tck_d, tms_q, tdi_q, tck_rise;
    always_ff @(posedge clk) begin
        if (rst) begin
            tck_q <= 1'b0;
            tck_d <= 1'b0;
            tms_q <= 1'b1;
            tdi_q <= 1'b0;
        end else begin
            tck_q <= tck;
            tck_d <= tck_q;
            tms_q <= tms;
            tdi_q <= tdi;
        end
    end
    assign tck_rise = tck_q && !tck_d;

    tap_state_t      state;
    logic            rd_go, wr_go;
    logic [DW-1:0]   shift_q, rd_hold;
    logic [AW-1:0]   addr_q;

    jdb_tap_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tck_rise (tck_rise),
        .tms      (tms_q),
        .state    (state)
    );

    jdb_dr_chain #(
        .IR_W   (IR_W),
        .DW     (DW),
        .AW     (AW),
        .LB_W   (LB_W),
        .ID_VAL (ID_VAL)
    ) u_chain (
        .clk      (clk),
        .rst      (rst),
        .tck_rise (tck_rise),
        .tdi      (tdi_q),
        .state    (state),
        .lb_in    (lb_in),
        .lb_out   (lb_out),
        .rd_data  (rd_hold),
        .rd_go    (rd_go),
        .wr_go    (wr_go),
        .shift_q  (shift_q),
        .addr_q   (addr_q),
        .tdo      (tdo)
    );

    jdb_dmi_seq #(
        .DW (DW),
        .AW (AW)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .rd_go    (rd_go),
        .wr_go    (wr_go),
        .addr_in  (addr_q),
        .wdata_in (shift_q),
        .dm_req   (dm_req),
        .dm_we    (dm_we),
        .dm_addr  (dm_addr),
        .dm_wdata (dm_wdata),
        .dm_ack   (dm_ack),
        .dm_rdata (dm_rdata),
        .rd_hold  (rd_hold)
    );

    assert_tdo_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state == TS_IDLE || state == TS_RESET) |-> !tdo);

endmodule

// File: tb/tb_jtag_dmi_bridge.sv
module tb_jtag_dmi_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tck = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic        tdo;
    logic [2:0]  lb_in, lb_out;
    logic        dm_req, dm_we, dm_ack;
    logic [7:0]  dm_addr;
    logic [63:0] dm_wdata, dm_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign lb_in = lb_out;

    jtag_dmi_bridge dut (
        .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .lb_in(lb_in), .lb_out(lb_out),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_ack(dm_ack), .dm_rdata(dm_rdata)
    );

    // ---------------- debug-module model ----------------
    logic [63:0] mem [0:255];
    logic [1:0]  lat;
    logic        poke_en = 1'b0;
    logic [63:0] poke_val = '0;
    logic        op_we_q[$];
    logic [7:0]  op_addr_q[$];

    function automatic logic [63:0] seed(input int a);
        return {32'hC0DE_0000 + 32'(a), 32'h5A5A_5A5A ^ 32'(a)};
    endfunction

    always @(posedge clk) begin
        dm_ack <= 1'b0;
        if (rst) begin
            lat      <= '0;
            dm_rdata <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= seed(i);
        end else begin
            if (poke_en) mem[3] <= poke_val;
            if (dm_req && !dm_ack) begin
                if (lat == 2'd2) begin
                    dm_ack   <= 1'b1;
                    lat      <= '0;
                    dm_rdata <= mem[dm_addr];
                    if (dm_we) mem[dm_addr] <= dm_wdata;
                    op_we_q.push_back(dm_we);
                    op_addr_q.push_back(dm_addr);
                end else begin
                    lat <= lat + 2'd1;
                end
            end
        end
    end

    // handshake watcher
    logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [7:0]  p_addr = '0;
    logic [63:0] p_wd = '0;
    int          hs_bad = 0;
    always @(posedge clk) begin
        if (!rst && p_req && !p_ack &&
            (!dm_req || dm_addr != p_addr || dm_wdata != p_wd || dm_we != p_we))
            hs_bad <= hs_bad + 1;
        p_req <= dm_req; p_ack <= dm_ack; p_we <= dm_we;
        p_addr <= dm_addr; p_wd <= dm_wdata;
    end

    // ---------------- scoreboard ----------------
    string       tag_q[$];
    logic [63:0] exp_q[$];
    logic [63:0] act_q[$];
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    task automatic sb_expect(input string t, input logic [63:0] v);
        tag_q.push_back(t);
        exp_q.push_back(v);
    endtask

    task automatic sb_actual(input logic [63:0] v);
        act_q.push_back(v);
    endtask

    initial begin : monitor
        logic [63:0] e, a;
        string t;
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                a = act_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- JTAG driver ----------------
    task automatic tck_cycle(input logic m, input logic d, output logic o);
        @(negedge clk);
        tms = m; tdi = d; tck = 1'b0;
        repeat (3) @(negedge clk);
        tck = 1'b1;
        @(negedge clk);
        o = tdo;              // sampled while TCK is high, before the shift lands
        repeat (2) @(negedge clk);
    endtask

    task automatic walk(input logic m);
        logic o;
        tck_cycle(m, 1'b0, o);
    endtask

    task automatic ir_scan(input logic [3:0] code, output logic [3:0] got);
        logic b;
        walk(1); walk(1); walk(0); walk(0);
        for (int i = 0; i < 4; i++) begin
            tck_cycle(i == 3, code[i], b);
            got[i] = b;
        end
        walk(1); walk(0);
    endtask

    task automatic dr_scan(input int len, input logic [63:0] din, output logic [63:0] got);
        logic b;
        got = '0;
        walk(1); walk(0); walk(0);
        for (int i = 0; i < len; i++) begin
            tck_cycle(i == len - 1, din[i], b);
            got[i] = b;
        end
        walk(1); walk(0);
    endtask

    task automatic set_ir(input logic [3:0] code);
        logic [3:0] g;
        sb_expect("R2 instruction capture", 64'd1);
        ir_scan(code, g);
        sb_actual({60'd0, g});
    endtask

    task automatic check_dr(input string t, input int len,
                            input logic [63:0] din, input logic [63:0] expv);
        logic [63:0] g;
        sb_expect(t, expv);
        dr_scan(len, din, g);
        sb_actual(g);
    endtask

    localparam logic [63:0] W1 = 64'h0011_2233_4455_6677;
    localparam logic [63:0] W2 = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] PV = 64'hA1B2_C3D4_E5F6_0718;

    initial begin : stimulus
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        sb_expect("R11 tdo after reset", 64'd0);   sb_actual({63'd0, tdo});
        sb_expect("R11 dm_req after reset", 64'd0); sb_actual({63'd0, dm_req});

        walk(0);   // Test-Logic-Reset -> Idle
        check_dr("R3 R1 identification after reset", 32, 64'd0, 64'h18FF);

        // bypass at both ends of the unused codes
        set_ir(4'd0);
        check_dr("R5 bypass code 0", 8, 64'hB5, 64'h6A);
        set_ir(4'd15);
        check_dr("R5 bypass code 15", 8, 64'h3C, 64'h78);

        // loop register
        set_ir(4'd4);
        check_dr("R4 loop first scan", 3, 64'b101, 64'b000);
        sb_expect("R4 lb_out after first update", 64'b101); sb_actual({61'd0, lb_out});
        check_dr("R4 loop second scan", 3, 64'b010, 64'b101);
        sb_expect("R4 lb_out after second update", 64'b010); sb_actual({61'd0, lb_out});

        // five TMS-high rises from Shift-DR
        walk(1); walk(0); walk(0);
        repeat (5) walk(1);
        walk(0);
        sb_expect("R10 tdo quiet in Idle", 64'd0); sb_actual({63'd0, tdo});
        check_dr("R1 identification after TMS reset", 32, 64'd0, 64'h18FF);

        // address register
        set_ir(4'd5);
        check_dr("R6 address reset value", 8, 64'h2A, 64'h00);
        check_dr("R6 address readback", 8, 64'h03, 64'h2A);

        // read with prefetch at instruction update
        set_ir(4'd6);
        check_dr("R7 read of address 3", 64, 64'h0, seed(3));
        sb_expect("R6 dm_addr holds address", 64'd3); sb_actual({56'd0, dm_addr});

        // write-and-read
        set_ir(4'd7);
        check_dr("R8 write returns old value", 64, W1, seed(3));
        repeat (20) @(negedge clk);
        sb_expect("R8 model holds written data", W1); sb_actual(mem[3]);
        sb_expect("R8 write then read order", 64'b10);
        sb_actual({62'd0, op_we_q[op_we_q.size()-2], op_we_q[op_we_q.size()-1]});
        check_dr("R8 second write returns first data", 64, W2, W1);
        repeat (20) @(negedge clk);

        // stale vs fresh capture
        set_ir(4'd6);
        check_dr("R7 read after writes", 64, 64'h0, W2);
        repeat (20) @(negedge clk);
        poke_en = 1'b1; poke_val = PV;
        @(negedge clk);
        poke_en = 1'b0;
        check_dr("R7 capture is from previous read", 64, 64'h0, W2);
        repeat (20) @(negedge clk);
        check_dr("R7 capture sees changed data", 64, 64'h0, PV);

        repeat (5) @(negedge clk);
        sb_expect("R9 handshake violations", 64'd0); sb_actual(64'(hs_bad));

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule